// File: doc/BRIEF.md
# ADC Result Window Comparator

This block watches the stream of finished conversion results coming out of a multi-slot ADC sequencer and tells software when one chosen slot has produced a run of results that all satisfy a threshold test. Each result arrives as a one-cycle valid strobe that carries the slot index and a 12-bit value. The block holds two independent comparator units, and both see every result. Each unit is programmed with an enable, the slot it listens to, a direction bit, a 12-bit threshold and a 4-bit run length. It reports three things: the outcome of the most recent evaluated result, a sticky flag once enough qualifying results have arrived back to back, and an interrupt request gated by its own enable.

The two units share one status word. Software clears its bits by writing ones. Bits 0 to 3 of the word belong to neighbouring logic and always read zero from this block. Each unit is built around a three-state machine:
- OFF: the unit is disabled.
- ARM: enabled, with no qualifying results counted yet.
- RUN: enabled, with a partial run counted.

The transitions are:
- ENABLE (OFF to ARM): the enable is high.
- DISABLE (any state to OFF): the enable is low.
- START (OFF or ARM to RUN): a qualifying result arrives when more than one is required.
- ADVANCE (RUN to RUN): a qualifying result arrives that is not the last one needed.
- BREAK (RUN to ARM): a failing result arrives from the selected slot.
- FIRE (ARM or RUN to ARM): the last qualifying result of a run arrives. The flag is set and counting starts again.

Top module: `adc_match_monitor`

## Requirements
- R1: After reset, every bit of `status_word` and every bit of `irq` is 0.
- R2: When the direction bit of unit i is 0, a result qualifies if it is strictly below the threshold. When the bit is 1, a result qualifies if it is at or above the threshold. The status bit at position 4+i is updated one cycle after each evaluated result and shows whether that result qualified.
- R3: A result is evaluated only if the valid strobe is high and the slot index equals the unit's selected slot. Any other result, and any cycle without the strobe, leaves the unit's status bits and run count unchanged.
- R4: With a run-length field of M (0 to 15), the flag at status bit 6+i sets one cycle after the (M+1)th consecutive qualifying result. M=0 sets it on the first qualifying result and M=15 on the sixteenth.
- R5: A result from the selected slot that fails the test discards the partial run, so M+1 further qualifying results are needed.
- R6: When the flag sets, the run count restarts from zero. After the flag is cleared, a complete new run of M+1 results is needed to set it again.
- R7: `irq[i]` is high exactly while unit i's flag is set, its interrupt enable is high and the unit is enabled. It therefore rises in the same cycle as the flag.
- R8: A clear write with a 1 in bit 4+i or bit 6+i clears that bit, and a 0 in a bit has no effect. If an evaluated result updates or sets the same bit in the same cycle, the update wins.
- R9: While a unit's enable is low, its run count is held at zero, its compare bit (4+i) is 0 and its `irq` is 0. An already-set flag is kept until it is cleared.
- R10: The two units share no state. A result or clear that concerns one unit never changes the other unit's bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_vld | input | 1 | One-cycle strobe marking a finished conversion |
| res_slot | input | SLOT_W (4) | Sample slot that produced the result |
| res_data | input | RES_W (12) | Conversion result |
| cfg_en | input | NCMP (2) | Per-unit enable |
| cfg_slot | input | NCMP*SLOT_W (8) | Per-unit selected slot, unit i at bits [i*SLOT_W +: SLOT_W] |
| cfg_dir | input | NCMP (2) | Per-unit direction: 0 below, 1 at-or-above |
| cfg_thresh | input | NCMP*RES_W (24) | Per-unit threshold, unit i at bits [i*RES_W +: RES_W] |
| cfg_runlen | input | NCMP*CNT_W (8) | Per-unit run length minus one |
| cfg_ie | input | NCMP (2) | Per-unit interrupt enable |
| clr_we | input | 1 | Strobe for a write-1-to-clear access to the status word |
| clr_data | input | STS_W (8) | Clear mask in status-word bit positions |
| status_word | output | STS_W (8) | Bits 4+i: compare outputs, bits 6+i: sticky flags, bits 0..3: zero |
| irq | output | NCMP (2) | Per-unit interrupt request |

## Verification
Two functions can fall in the same cycle: a clear write and an evaluated result that touches the same status bit. The most important case is the last qualifying result of a run arriving together with a write that clears the flag. The bench provokes this on purpose: it drives a clear of the flag and compare bits in the same cycle as a firing result, and it also mixes random clear masks into long random result streams. In both situations the outcome is judged against a bench model in which the update from the result takes priority over the clear. A second kind of overlap also occurs: results and clears for one unit arrive while the other unit is in the middle of a run. This shows that the two units stay independent.

// File: rtl/amm_pkg.sv
package amm_pkg;

    // Low status-word bits are owned by neighbouring logic.
    localparam int STS_BASE = 4;

    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_ARM = 2'd1,
        ST_RUN = 2'd2
    } cmp_state_e;

endpackage

// File: rtl/amm_threshold.sv
module amm_threshold #(
    parameter int RES_W = 12
) (
    input  logic [RES_W-1:0] sample,
    input  logic [RES_W-1:0] thresh,
    input  logic             dir_ge,
    output logic             pass
);

    always_comb begin
        if (dir_ge) begin
            pass = (sample >= thresh);
        end else begin
            pass = (sample < thresh);
        end
    end

endmodule

// File: rtl/amm_cmp_unit.sv
module amm_cmp_unit
    import amm_pkg::*;
#(
    parameter int RES_W  = 12,
    parameter int CNT_W  = 4,
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [SLOT_W-1:0] slot_sel,
    input  logic              dir_ge,
    input  logic [RES_W-1:0]  thresh,
    input  logic [CNT_W-1:0]  runlen,
    input  logic              res_vld,
    input  logic [SLOT_W-1:0] res_slot,
    input  logic [RES_W-1:0]  res_data,
    input  logic              clr_out,
    input  logic              clr_flag,
    output logic              cmp_out,
    output logic              flag
);

    cmp_state_e       state, nxt_state;
    logic [CNT_W-1:0] run_cnt, nxt_cnt;
    logic             sel;
    logic             pass;
    logic             last;
    logic             fire;

    amm_threshold #(
        .RES_W(RES_W)
    ) u_thr (
        .sample(res_data),
        .thresh(thresh),
        .dir_ge(dir_ge),
        .pass  (pass)
    );

    assign sel  = en && res_vld && (res_slot == slot_sel);
    assign last = (run_cnt == runlen);

    // Next-state and run-count decision.
    always_comb begin
        nxt_state = state;
        nxt_cnt   = run_cnt;
        fire      = 1'b0;
        unique case (state)
            ST_OFF, ST_ARM: begin
                if (!en) begin
                    nxt_state = ST_OFF;
                    nxt_cnt   = '0;
                end else if (sel && pass) begin
                    if (runlen == '0) begin
                        fire      = 1'b1;
                        nxt_state = ST_ARM;
                        nxt_cnt   = '0;
                    end else begin
                        nxt_state = ST_RUN;
                        nxt_cnt   = CNT_W'(1);
                    end
                end else begin
                    nxt_state = ST_ARM;
                    nxt_cnt   = '0;
                end
            end
            ST_RUN: begin
                if (!en) begin
                    nxt_state = ST_OFF;
                    nxt_cnt   = '0;
                end else if (sel && !pass) begin
                    nxt_state = ST_ARM;
                    nxt_cnt   = '0;
                end else if (sel && pass) begin
                    if (last) begin
                        fire      = 1'b1;
                        nxt_state = ST_ARM;
                        nxt_cnt   = '0;
                    end else begin
                        nxt_cnt   = run_cnt + 1'b1;
                    end
                end
            end
            default: begin
                nxt_state = ST_OFF;
                nxt_cnt   = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_OFF;
            run_cnt <= '0;
        end else begin
            state   <= nxt_state;
            run_cnt <= nxt_cnt;
        end
    end

    // Output registers: updates from results take priority over clears.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_out <= 1'b0;
            flag    <= 1'b0;
        end else begin
            if (!en) begin
                cmp_out <= 1'b0;
            end else if (sel) begin
                cmp_out <= pass;
            end else if (clr_out) begin
                cmp_out <= 1'b0;
            end

            if (fire) begin
                flag <= 1'b1;
            end else if (clr_flag) begin
                flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/adc_match_monitor.sv
module adc_match_monitor
    import amm_pkg::*;
#(
    parameter int NCMP   = 2,
    parameter int RES_W  = 12,
    parameter int CNT_W  = 4,
    parameter int SLOT_W = 4,
    localparam int OUT_LO = STS_BASE,
    localparam int FLG_LO = STS_BASE + NCMP,
    localparam int STS_W  = STS_BASE + 2 * NCMP
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     res_vld,
    input  logic [SLOT_W-1:0]        res_slot,
    input  logic [RES_W-1:0]         res_data,
    input  logic [NCMP-1:0]          cfg_en,
    input  logic [NCMP*SLOT_W-1:0]   cfg_slot,
    input  logic [NCMP-1:0]          cfg_dir,
    input  logic [NCMP*RES_W-1:0]    cfg_thresh,
    input  logic [NCMP*CNT_W-1:0]    cfg_runlen,
    input  logic [NCMP-1:0]          cfg_ie,
    input  logic                     clr_we,
    input  logic [STS_W-1:0]         clr_data,
    output logic [STS_W-1:0]         status_word,
    output logic [NCMP-1:0]          irq
);

    logic [NCMP-1:0] cmp_bits;
    logic [NCMP-1:0] flag_bits;

    for (genvar i = 0; i < NCMP; i++) begin : g_unit
        amm_cmp_unit #(
            .RES_W (RES_W),
            .CNT_W (CNT_W),
            .SLOT_W(SLOT_W)
        ) u_unit (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (cfg_en[i]),
            .slot_sel(cfg_slot[i*SLOT_W +: SLOT_W]),
            .dir_ge  (cfg_dir[i]),
            .thresh  (cfg_thresh[i*RES_W +: RES_W]),
            .runlen  (cfg_runlen[i*CNT_W +: CNT_W]),
            .res_vld (res_vld),
            .res_slot(res_slot),
            .res_data(res_data),
            .clr_out (clr_we && clr_data[OUT_LO + i]),
            .clr_flag(clr_we && clr_data[FLG_LO + i]),
            .cmp_out (cmp_bits[i]),
            .flag    (flag_bits[i])
        );

        assign irq[i] = flag_bits[i] && cfg_ie[i] && cfg_en[i];
    end

    always_comb begin
        status_word = '0;
        status_word[OUT_LO +: NCMP] = cmp_bits;
        status_word[FLG_LO +: NCMP] = flag_bits;
    end

endmodule

// File: rtl/amm_checker.sv
module amm_checker #(
    parameter int NCMP   = 2,
    parameter int SLOT_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   res_vld,
    input logic [SLOT_W-1:0]      res_slot,
    input logic [NCMP-1:0]        cfg_en,
    input logic [NCMP*SLOT_W-1:0] cfg_slot,
    input logic                   clr_we,
    input logic [NCMP-1:0]        clr_out_mask,
    input logic [NCMP-1:0]        clr_flag_mask,
    input logic [NCMP-1:0]        cmp_bits,
    input logic [NCMP-1:0]        flag_bits
);

    for (genvar i = 0; i < NCMP; i++) begin : g_chk
        // R3: no evaluated result and no clear leaves the unit's bits alone
        a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_en[i] && !(res_vld && res_slot == cfg_slot[i*SLOT_W +: SLOT_W]) && !clr_we)
            |=> ($stable(cmp_bits[i]) && $stable(flag_bits[i])));

        // R4: the flag only rises right after a result from the selected slot
        a_r4_rise_after_result: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_bits[i])
            |-> $past(cfg_en[i] && res_vld && res_slot == cfg_slot[i*SLOT_W +: SLOT_W]));

        // R8: the flag only falls after a clear write naming it
        a_r8_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag_bits[i]) |-> $past(clr_we && clr_flag_mask[i]));

        // R8: the compare bit only falls through a clear, a failing result or disable
        a_r8_out_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(cmp_bits[i])
            |-> $past((clr_we && clr_out_mask[i]) || !cfg_en[i]
                      || (res_vld && res_slot == cfg_slot[i*SLOT_W +: SLOT_W])));

        // R9: a disabled unit shows a zero compare bit
        a_r9_disable_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_en[i] |=> !cmp_bits[i]);
    end

endmodule

bind adc_match_monitor amm_checker #(
    .NCMP  (NCMP),
    .SLOT_W(SLOT_W)
) u_amm_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .res_vld      (res_vld),
    .res_slot     (res_slot),
    .cfg_en       (cfg_en),
    .cfg_slot     (cfg_slot),
    .clr_we       (clr_we),
    .clr_out_mask (clr_data[OUT_LO +: NCMP]),
    .clr_flag_mask(clr_data[FLG_LO +: NCMP]),
    .cmp_bits     (status_word[OUT_LO +: NCMP]),
    .flag_bits    (status_word[FLG_LO +: NCMP])
);

// File: tb/adc_match_monitor_bench.sv
module adc_match_monitor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCMP   = 2;
    localparam int RES_W  = 12;
    localparam int CNT_W  = 4;
    localparam int SLOT_W = 4;
    localparam int STS_W  = 8;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   res_vld = 1'b0;
    logic [SLOT_W-1:0]      res_slot = '0;
    logic [RES_W-1:0]       res_data = '0;
    logic [NCMP-1:0]        cfg_en = '0;
    logic [NCMP*SLOT_W-1:0] cfg_slot = '0;
    logic [NCMP-1:0]        cfg_dir = '0;
    logic [NCMP*RES_W-1:0]  cfg_thresh = '0;
    logic [NCMP*CNT_W-1:0]  cfg_runlen = '0;
    logic [NCMP-1:0]        cfg_ie = '0;
    logic                   clr_we = 1'b0;
    logic [STS_W-1:0]       clr_data = '0;
    logic [STS_W-1:0]       status_word;
    logic [NCMP-1:0]        irq;

    int vectors = 0;
    int fails = 0;

    // Bench model state
    logic [CNT_W-1:0] m_cnt  [NCMP];
    logic             m_out  [NCMP];
    logic             m_flag [NCMP];

    adc_match_monitor #(
        .NCMP(NCMP), .RES_W(RES_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W)
    ) u_adc_match_monitor (
        .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .res_slot(res_slot),
        .res_data(res_data), .cfg_en(cfg_en), .cfg_slot(cfg_slot),
        .cfg_dir(cfg_dir), .cfg_thresh(cfg_thresh), .cfg_runlen(cfg_runlen),
        .cfg_ie(cfg_ie), .clr_we(clr_we), .clr_data(clr_data),
        .status_word(status_word), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic qualifies(input logic dir, input logic [RES_W-1:0] d,
                                       input logic [RES_W-1:0] t);
        return dir ? (d >= t) : (d < t);
    endfunction

    function automatic logic [STS_W-1:0] exp_word();
        logic [STS_W-1:0] w = '0;
        for (int i = 0; i < NCMP; i++) begin
            w[4 + i] = m_out[i];
            w[6 + i] = m_flag[i];
        end
        return w;
    endfunction

    function automatic logic [NCMP-1:0] exp_irq();
        logic [NCMP-1:0] q = '0;
        for (int i = 0; i < NCMP; i++) q[i] = m_flag[i] && cfg_ie[i] && cfg_en[i];
        return q;
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    // Apply the currently driven inputs for one clock and compare.
    task automatic step(input string tag);
        logic [CNT_W-1:0] n_cnt [NCMP];
        logic n_out [NCMP];
        logic n_flag [NCMP];
        for (int i = 0; i < NCMP; i++) begin
            logic sel, hit, fire;
            logic [CNT_W-1:0] m;
            m    = cfg_runlen[i*CNT_W +: CNT_W];
            sel  = cfg_en[i] && res_vld && (res_slot == cfg_slot[i*SLOT_W +: SLOT_W]);
            hit  = qualifies(cfg_dir[i], res_data, cfg_thresh[i*RES_W +: RES_W]);
            fire = sel && hit && (m_cnt[i] == m);
            if (!cfg_en[i]) n_cnt[i] = '0;
            else if (sel) n_cnt[i] = (hit && !fire) ? m_cnt[i] + 1'b1 : '0;
            else n_cnt[i] = m_cnt[i];
            if (!cfg_en[i]) n_out[i] = 1'b0;
            else if (sel) n_out[i] = hit;
            else if (clr_we && clr_data[4 + i]) n_out[i] = 1'b0;
            else n_out[i] = m_out[i];
            if (fire) n_flag[i] = 1'b1;
            else if (clr_we && clr_data[6 + i]) n_flag[i] = 1'b0;
            else n_flag[i] = m_flag[i];
        end
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < NCMP; i++) begin
            m_cnt[i] = n_cnt[i];
            m_out[i] = n_out[i];
            m_flag[i] = n_flag[i];
        end
        vectors++;
        if (status_word !== exp_word()) begin
            fails++;
            $display("FAIL %s status_word got %h exp %h", tag, status_word, exp_word());
        end
        if (irq !== exp_irq()) begin
            fails++;
            $display("FAIL %s (R7) irq got %b exp %b", tag, irq, exp_irq());
        end
    endtask

    task automatic quiet();
        res_vld = 1'b0;
        clr_we  = 1'b0;
        clr_data = '0;
    endtask

    task automatic feed(input logic [SLOT_W-1:0] s, input logic [RES_W-1:0] d,
                        input string tag);
        quiet();
        res_vld = 1'b1; res_slot = s; res_data = d;
        step(tag);
        quiet();
    endtask

    task automatic clear(input logic [STS_W-1:0] mask, input string tag);
        quiet();
        clr_we = 1'b1; clr_data = mask;
        step(tag);
        quiet();
    endtask

    task automatic config_unit(input int i, input logic en, input logic [SLOT_W-1:0] s,
                               input logic dir, input logic [RES_W-1:0] t,
                               input logic [CNT_W-1:0] m, input logic ie);
        cfg_en[i] = en;
        cfg_slot[i*SLOT_W +: SLOT_W] = s;
        cfg_dir[i] = dir;
        cfg_thresh[i*RES_W +: RES_W] = t;
        cfg_runlen[i*CNT_W +: CNT_W] = m;
        cfg_ie[i] = ie;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < NCMP; i++) begin
            m_cnt[i] = '0; m_out[i] = 1'b0; m_flag[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        vectors++;
        if (status_word !== '0 || irq !== '0) begin
            fails++;
            $display("FAIL R1 reset status %h irq %b exp 00 00", status_word, irq);
        end

        config_unit(0, 1'b1, 4'd3, 1'b1, 12'h800, 4'd2, 1'b1);
        config_unit(1, 1'b1, 4'd5, 1'b0, 12'h100, 4'd0, 1'b0);
        step("R9");

        // R2: boundary of the at-or-above test, then a failing value
        feed(4'd3, 12'h800, "R2");
        feed(4'd3, 12'h7FF, "R2");
        // R3: other slots and missing strobe change nothing
        feed(4'd7, 12'hFFF, "R3");
        quiet(); res_slot = 4'd3; res_data = 12'hFFF; step("R3");
        // R4: three qualifying results with an unrelated slot between them
        feed(4'd3, 12'h900, "R4");
        feed(4'd3, 12'hA00, "R4");
        feed(4'd6, 12'h000, "R3");
        feed(4'd3, 12'hFFF, "R4");
        // R8: zero mask has no effect, then clear
        clear(8'h0F, "R8");
        clear(8'h40, "R8");
        // R5: a failing result discards the partial run
        feed(4'd3, 12'h900, "R5");
        feed(4'd3, 12'h900, "R5");
        feed(4'd3, 12'h001, "R5");
        feed(4'd3, 12'h900, "R5");
        feed(4'd3, 12'h900, "R5");
        feed(4'd3, 12'h900, "R5");
        // R6: the run restarts after firing
        clear(8'h40, "R6");
        feed(4'd3, 12'h900, "R6");
        feed(4'd3, 12'h900, "R6");
        // R8: firing result coincides with a clear of the same bits
        quiet();
        res_vld = 1'b1; res_slot = 4'd3; res_data = 12'hC00;
        clr_we = 1'b1; clr_data = 8'h50;
        step("R8");
        quiet();
        // R10: unit 1 fires on its first result below 0x100, unit 0 untouched
        feed(4'd5, 12'h0FF, "R10");
        feed(4'd5, 12'h100, "R10");
        clear(8'h80, "R10");
        // R9: disable mid-run drops count and compare bit, keeps flag
        feed(4'd3, 12'h900, "R9");
        feed(4'd3, 12'h900, "R9");
        cfg_en[0] = 1'b0;
        step("R9");
        feed(4'd3, 12'h900, "R9");
        cfg_en[0] = 1'b1;
        feed(4'd3, 12'h900, "R9");
        feed(4'd3, 12'h900, "R9");
        clear(8'hF0, "R9");
        // R4: sixteen-result run, both ends of the threshold range
        config_unit(0, 1'b1, 4'd3, 1'b0, 12'hFFF, 4'd15, 1'b1);
        config_unit(1, 1'b1, 4'd3, 1'b0, 12'h000, 4'd0, 1'b1);
        for (int k = 0; k < 17; k++) feed(4'd3, 12'hFFE, "R4");
        clear(8'hF0, "R8");

        // Random phases
        for (int p = 0; p < 24; p++) begin
            cfg_en = '0;
            quiet();
            step("R9");
            for (int i = 0; i < NCMP; i++) begin
                config_unit(i, 1'b1, 4'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                            12'($urandom_range(0, 4095)),
                            ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15))
                                                        : 4'($urandom_range(0, 3)),
                            1'($urandom_range(0, 1)));
            end
            for (int k = 0; k < 180; k++) begin
                int u;
                quiet();
                u = $urandom_range(0, NCMP - 1);
                res_vld  = ($urandom_range(0, 9) < 7);
                res_slot = 4'($urandom_range(0, 4));
                if ($urandom_range(0, 1) == 1)
                    res_data = 12'($urandom_range(0, 4095));
                else
                    res_data = cfg_thresh[u*RES_W +: RES_W] + 12'($urandom_range(0, 6)) - 12'd3;
                if ($urandom_range(0, 9) == 0) begin
                    clr_we = 1'b1;
                    clr_data = 8'($urandom_range(0, 255));
                end
                if ($urandom_range(0, 199) == 0) cfg_en[u] = ~cfg_en[u];
                step("R4");
            end
        end

        summary();
        $finish;
    end

endmodule